// File: doc/BRIEF.md
# Self-Correcting Decade Ring Counter

This block is a five-stage twisted-ring counter that steps through ten states and presents its position as ten one-hot outputs. A further output goes low for the upper half of the count (states 5 to 9). That output rises when the count wraps back to 0, so it can serve as the count input of a following counter to build a longer chain.

The counter has two count inputs of opposite edge polarity, and each input gates the other. A rising edge on the positive input counts while the negative input is low. A falling edge on the negative input counts while the positive input is high. Both inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer and is then compared with its previous sample. At most one count is applied per system clock.

An active-high master reset forces state 0 at once, whatever the count inputs are doing. The next-state logic contains a correction term, so the ring cannot stay in any of the 22 patterns that lie outside the legal sequence. The ring's combinational next-state function is its own module, `decade_ring_next`.

Top module: `decade_johnson_counter`

## Requirements
- R1: While `rst` is high, `state_dec_o` is 10'b0000000001 and `upper_half_n_o` is 1, and toggling the count inputs changes neither. The reset takes effect without waiting for a clock edge.
- R2: A rising edge on `step_rise_i` while `step_fall_n_i` is low advances the count by one.
- R3: A rising edge on `step_rise_i` while `step_fall_n_i` is high leaves the count unchanged.
- R4: A falling edge on `step_fall_n_i` while `step_rise_i` is high advances the count by one.
- R5: A falling edge on `step_fall_n_i` while `step_rise_i` is low leaves the count unchanged.
- R6: Exactly one bit of `state_dec_o` is high, and bit k is high in state k. The ring sequence is 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000, after which it returns to 00000, so state 9 wraps to state 0.
- R7: `upper_half_n_o` is 0 in states 5 to 9 and 1 in states 0 to 4, so it rises on the wrap from 9 to 0.
- R8: After an input edge is applied between clock edges, the decoded output changes right after the third rising clock edge that follows.
- R9: If a qualifying rise and a qualifying fall appear in the same sample, the counter advances by exactly one.
- R10: From each of the 22 illegal five-bit ring patterns, `decade_ring_next` reaches a legal pattern within 11 steps. It maps every legal pattern to its successor in the R6 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the count inputs |
| rst | input | 1 | Asynchronous active-high master reset to state 0 |
| step_rise_i | input | 1 | Count input, rising-edge active, gated by `step_fall_n_i` low |
| step_fall_n_i | input | 1 | Count input, falling-edge active, gated by `step_rise_i` high |
| state_dec_o | output | 10 | One-hot decoded state, bit k high in state k |
| upper_half_n_o | output | 1 | Low in states 5 to 9; rising edge marks the wrap to 0 |

## Verification
An input edge driven at a falling clock edge is due at the outputs just after the third rising edge that follows. The three stages are synchronizer, edge register and ring. The reference model is behavioural: a count and a short history of sampled inputs. It advances on the same rising edge as the design and is compared at every falling edge, so each result is read half a cycle after it settles. Reset is checked one time unit after it is asserted, away from any clock edge. The correction is checked on the next-state module alone, which is stepped combinationally from every illegal pattern.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int RING_LEN_DEF    = 5;
  localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/decade_edge_sync.sv
module decade_edge_sync #(
  parameter int STAGES      = 2,
  parameter bit DETECT_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o,
  output logic edge_o
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] the prior sample
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], raw_i};
  end

  assign level_o = pipe[STAGES-1];

  generate
    if (DETECT_RISE) begin : g_rise
      assign edge_o = pipe[STAGES-1] & ~pipe[STAGES];
    end else begin : g_fall
      assign edge_o = ~pipe[STAGES-1] & pipe[STAGES];
    end
  endgenerate
endmodule

// File: rtl/decade_ring_next.sv
module decade_ring_next #(
  parameter int RING_LEN = 5
) (
  input  logic [RING_LEN-1:0] cur_i,
  output logic [RING_LEN-1:0] nxt_o
);
  // Twisted shift: stage 0 takes the inverted top bit.
  assign nxt_o[0] = ~cur_i[RING_LEN-1];

  generate
    for (genvar i = 1; i < RING_LEN; i++) begin : g_stage
      if (i == 2) begin : g_fix
        // A lone 1 in stage 1 (stages 0 and 2 both 0) never occurs in a
        // legal state; dropping it breaks every illegal orbit.
        assign nxt_o[i] = cur_i[1] & (cur_i[2] | cur_i[0]);
      end else begin : g_plain
        assign nxt_o[i] = cur_i[i-1];
      end
    end
  endgenerate
endmodule

// File: rtl/decade_ring_reg.sv
module decade_ring_reg #(
  parameter int RING_LEN = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv_i,
  output logic [RING_LEN-1:0] ring_o
);
  logic [RING_LEN-1:0] ring_q;
  logic [RING_LEN-1:0] ring_nxt;

  decade_ring_next #(.RING_LEN(RING_LEN)) i_next (
    .cur_i (ring_q),
    .nxt_o (ring_nxt)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        ring_q <= '0;
    else if (adv_i) ring_q <= ring_nxt;
  end

  assign ring_o = ring_q;

  // R3
  ring_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(ring_q));

  // R6
  ring_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> ring_q == {$past(ring_q[RING_LEN-2:0]), ~$past(ring_q[RING_LEN-1])});
endmodule

// File: rtl/decade_ring_decode.sv
module decade_ring_decode #(
  parameter int RING_LEN = 5,
  localparam int NUM_STATES = 2 * RING_LEN
) (
  input  logic [RING_LEN-1:0]   ring_i,
  output logic [NUM_STATES-1:0] dec_o,
  output logic                  upper_n_o
);
  generate
    for (genvar k = 0; k < NUM_STATES; k++) begin : g_dec
      if (k == 0) begin : g_zero
        assign dec_o[k] = ~ring_i[RING_LEN-1] & ~ring_i[0];
      end else if (k == RING_LEN) begin : g_full
        assign dec_o[k] = ring_i[RING_LEN-1] & ring_i[0];
      end else if (k < RING_LEN) begin : g_fill
        assign dec_o[k] = ring_i[k-1] & ~ring_i[k];
      end else begin : g_drain
        assign dec_o[k] = ~ring_i[k-RING_LEN-1] & ring_i[k-RING_LEN];
      end
    end
  endgenerate

  assign upper_n_o = ~ring_i[RING_LEN-1];
endmodule

// File: rtl/decade_johnson_counter.sv
module decade_johnson_counter
  import decade_pkg::*;
#(
  parameter int RING_LEN    = RING_LEN_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF,
  localparam int NUM_STATES = 2 * RING_LEN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step_rise_i,
  input  logic                  step_fall_n_i,
  output logic [NUM_STATES-1:0] state_dec_o,
  output logic                  upper_half_n_o
);
  logic rise_lvl, rise_edge;
  logic fall_lvl, fall_edge;
  logic advance;
  logic [RING_LEN-1:0] ring;

  decade_edge_sync #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b1)) i_rise_sync (
    .clk     (clk),
    .rst     (rst),
    .raw_i   (step_rise_i),
    .level_o (rise_lvl),
    .edge_o  (rise_edge)
  );

  decade_edge_sync #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b0)) i_fall_sync (
    .clk     (clk),
    .rst     (rst),
    .raw_i   (step_fall_n_i),
    .level_o (fall_lvl),
    .edge_o  (fall_edge)
  );

  // Each count input is gated by the synchronized level of the other;
  // a double event in one sample still yields a single advance.
  assign advance = (rise_edge & ~fall_lvl) | (fall_edge & rise_lvl);

  decade_ring_reg #(.RING_LEN(RING_LEN)) i_ring (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (advance),
    .ring_o (ring)
  );

  decade_ring_decode #(.RING_LEN(RING_LEN)) i_decode (
    .ring_i    (ring),
    .dec_o     (state_dec_o),
    .upper_n_o (upper_half_n_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |-> (state_dec_o == NUM_STATES'(1) && upper_half_n_o));

  // R6
  one_hot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(state_dec_o) == 1);

  // R7
  upper_half_chk: assert property (@(posedge clk) disable iff (rst)
    upper_half_n_o == ~(|state_dec_o[NUM_STATES-1:RING_LEN]));

  // R7
  wrap_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(upper_half_n_o) |-> state_dec_o[0]);
endmodule

// File: tb/test_decade_johnson_counter.sv
module test_decade_johnson_counter;
  localparam int RL = 5;
  localparam int NS = 2 * RL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rise_in = 1'b0;
  logic fall_n_in = 1'b0;
  logic [NS-1:0] dec;
  logic upper_n;

  always #5 clk = ~clk;

  decade_johnson_counter i_decade_johnson_counter (
    .clk            (clk),
    .rst            (rst),
    .step_rise_i    (rise_in),
    .step_fall_n_i  (fall_n_in),
    .state_dec_o    (dec),
    .upper_half_n_o (upper_n)
  );

  // Standalone next-state function for the correction sweep (R10)
  logic [RL-1:0] probe = '0;
  logic [RL-1:0] probe_nxt;
  decade_ring_next #(.RING_LEN(RL)) i_probe_next (.cur_i(probe), .nxt_o(probe_nxt));

  int    vectors = 0;
  int    errors  = 0;
  string req     = "R1";
  bit    done    = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model: a count plus the history of input samples
  int       m_state = 0;
  logic [2:0] h_r = '0;
  logic [2:0] h_f = '0;
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_state <= 0;
      h_r <= '0;
      h_f <= '0;
    end else begin
      if ((h_r[1] && !h_r[2] && !h_f[1]) || (!h_f[1] && h_f[2] && h_r[1]))
        m_state <= (m_state + 1) % NS;
      h_r <= {h_r[1:0], rise_in};
      h_f <= {h_f[1:0], fall_n_in};
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(req, 32'(dec), 32'(1) << m_state);
      check("R7", 32'(upper_n), 32'(m_state < RL));
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rise();
    rise_in = 1'b1; wait_n(4);
    rise_in = 1'b0; wait_n(4);
  endtask

  function automatic logic [RL-1:0] jpat(int k);
    int t;
    if (k <= RL) t = (1 << k) - 1;
    else         t = ((1 << RL) - 1) & ~((1 << (k - RL)) - 1);
    return t[RL-1:0];
  endfunction

  function automatic int legal_idx(logic [RL-1:0] p);
    for (int k = 0; k < NS; k++) if (jpat(k) == p) return k;
    return -1;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: inputs toggle while reset is held
    req = "R1";
    wait_n(2);
    rise_in = 1'b1; wait_n(3);
    fall_n_in = 1'b1; wait_n(3);
    rise_in = 1'b0; wait_n(3);
    fall_n_in = 1'b0; wait_n(3);
    check("R1", 32'(dec), 32'd1);
    check("R1", 32'(upper_n), 32'd1);
    rst = 1'b0; wait_n(4);

    // R2 / R6: twelve counts wrap once and land on state 2
    req = "R2";
    repeat (12) pulse_rise();
    check("R6", 32'(dec), 32'h004);

    // R3: rising edges with the other input high are ignored
    req = "R3";
    fall_n_in = 1'b1; wait_n(4);
    repeat (3) pulse_rise();
    check("R3", 32'(dec), 32'h004);

    // R4: falling edges with the positive input high count
    req = "R4";
    rise_in = 1'b1; wait_n(4);
    repeat (3) begin
      fall_n_in = 1'b0; wait_n(4);
      fall_n_in = 1'b1; wait_n(4);
    end
    check("R4", 32'(dec), 32'h020);
    check("R7", 32'(upper_n), 32'd0);
    rise_in = 1'b0; wait_n(4);

    // R5: falling edges with the positive input low are ignored
    req = "R5";
    repeat (3) begin
      fall_n_in = 1'b0; wait_n(4);
      fall_n_in = 1'b1; wait_n(4);
    end
    check("R5", 32'(dec), 32'h020);

    // R9: both qualifying edges in the same sample count once
    req = "R9";
    rise_in = 1'b1; fall_n_in = 1'b0; wait_n(6);
    check("R9", 32'(dec), 32'h040);
    rise_in = 1'b0; wait_n(4);

    // R8: output changes after the third rising clock edge
    req = "R8";
    rise_in = 1'b1;
    wait_n(1); check("R8", 32'(dec), 32'h040);
    wait_n(1); check("R8", 32'(dec), 32'h040);
    wait_n(1); check("R8", 32'(dec), 32'h080);
    rise_in = 1'b0; wait_n(4);

    // R1: reset in the middle of counting, with an edge in flight
    req = "R1";
    pulse_rise();
    rise_in = 1'b1; wait_n(1);
    rst = 1'b1; #1;
    check("R1", 32'(dec), 32'd1);
    check("R1", 32'(upper_n), 32'd1);
    wait_n(1); rise_in = 1'b0; wait_n(3);
    rst = 1'b0; wait_n(4);
    check("R1", 32'(dec), 32'd1);

    // R7: upper-half flag through a full cycle
    req = "R7";
    repeat (4) pulse_rise();
    check("R7", 32'(upper_n), 32'd1);
    pulse_rise();
    check("R7", 32'(upper_n), 32'd0);
    repeat (4) pulse_rise();
    check("R7", 32'(upper_n), 32'd0);
    pulse_rise();
    check("R7", 32'(upper_n), 32'd1);
    check("R6", 32'(dec), 32'd1);

    // R10: correction sweep over every five-bit pattern
    for (int p = 0; p < (1 << RL); p++) begin
      int idx;
      idx = legal_idx(p[RL-1:0]);
      probe = p[RL-1:0]; #1;
      if (idx >= 0) begin
        check("R6", 32'(probe_nxt), 32'(jpat((idx + 1) % NS)));
      end else begin
        logic [RL-1:0] cur;
        int steps;
        cur = p[RL-1:0];
        steps = 0;
        while (legal_idx(cur) < 0 && steps < 12) begin
          probe = cur; #1;
          cur = probe_nxt;
          steps++;
        end
        check("R10", 32'(steps <= 11), 32'd1);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule